// File: doc/BRIEF.md
# Converter Power-State Arbiter

This block decides whether the conversion circuitry of a data converter is powered. Two sources compete: a dedicated power-down pin driven from outside the chip, and one-cycle power-up and power-down commands that the serial command decoder raises when it recognises the matching instruction. The pin has the stronger vote. While it is asserted, the core stays off whatever software asks. A software power-down turns the core off even when the pin is low. A software power-down is undone either by a software power-up or by a high-then-low pulse on the pin.

The block drives `core_active_o`, which gates the conversion logic. The serial and command logic is never gated, so instructions keep arriving while the core is off. If the core turns off while a conversion is running, the block emits a one-cycle abort pulse. It then raises a data-invalid flag that stays up until a conversion finishes after the core has woken again. The consumer of the result word can use this flag to tag that word as untrustworthy.

The pin is asynchronous to the block clock and passes through a synchronizer of `SYNC_STAGES` flops (default 2). All latencies below assume the default.

Top module: `pdn_arbiter`

## Requirements
- R1: After reset is released with the pin low, `core_active_o` is 1, `conv_abort_o` is 0 and `data_invalid_o` is 0.
- R2: When the pin goes high, `core_active_o` drops to 0 after the second rising clock edge that samples it high. It stays 0 for as long as the synchronized pin is high, whatever the software strobes do.
- R3: A `sw_down_i` strobe sampled at a clock edge makes `core_active_o` 0 from that edge on, also with the pin low.
- R4: A `sw_up_i` strobe while the synchronized pin is high leaves `core_active_o` at 0. The core becomes active only once the synchronized pin is low again.
- R5: After a software power-down, with the pin low and steady, a `sw_up_i` strobe makes `core_active_o` 1 from the edge that samples it.
- R6: After a software power-down, a pin pulse high and then low wakes the core. `core_active_o` returns to 1 on the third rising edge after the pin is driven low.
- R7: When `sw_up_i` and `sw_down_i` are both 1 in the same cycle, the power-down wins and the core is off afterwards.
- R8: `conv_abort_o` is a single-cycle pulse. It is raised in the first cycle in which `core_active_o` is 0 after being 1, and only if `conv_busy_i` was 1 in the cycle before. Otherwise it stays 0.
- R9: `data_invalid_o` rises one cycle after an abort pulse. It falls one cycle after `conv_busy_i` drops from 1 to 0 while `core_active_o` is 1. A busy drop while the core is off leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin_i | input | 1 | Asynchronous hardware power-down pin, high = off |
| sw_up_i | input | 1 | One-cycle software power-up strobe |
| sw_down_i | input | 1 | One-cycle software power-down strobe |
| conv_busy_i | input | 1 | High while the core is converting |
| core_active_o | output | 1 | Enable for the conversion circuitry |
| conv_abort_o | output | 1 | One-cycle pulse: a running conversion was cut off |
| data_invalid_o | output | 1 | The next result after wake-up is unreliable |

## Verification
Two things can coincide in one cycle. A software power-down can meet a software power-up, and a software power-down can meet the falling edge of the synchronized pin, which would otherwise clear the latch. The bench forces both collisions with directed strobes, timed so that the pin edge reaches the end of the synchronizer in the same cycle. It expects the core to be off afterwards in both cases. Random stimulus then mixes strobes, pin pulses and busy toggles freely, and every cycle is compared against a reference model in the bench that keeps its own pin pipeline and latch.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  // Software latch update: a power-down request dominates every wake source.
  function automatic logic soft_off_next(input logic cur_off,
                                         input logic up,
                                         input logic down,
                                         input logic pin_fall);
    logic nxt;
    if (down)                nxt = 1'b1;
    else if (up || pin_fall) nxt = 1'b0;
    else                     nxt = cur_off;
    return nxt;
  endfunction

  // Core is on only when neither the pin nor the software latch holds it off.
  function automatic logic core_on(input logic pin_hi, input logic off_latched);
    return !pin_hi && !off_latched;
  endfunction

  // Invalid flag update: abort sets it, a completed conversion clears it.
  function automatic logic invalid_next(input logic cur_inv,
                                        input logic abort_evt,
                                        input logic done_evt);
    logic nxt;
    if (abort_evt)     nxt = 1'b1;
    else if (done_evt) nxt = 1'b0;
    else               nxt = cur_inv;
    return nxt;
  endfunction

endpackage

// File: rtl/pdn_pin_sync.sv
module pdn_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_sync_o,
  output logic pin_ahead_o,
  output logic pin_fall_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          last_q;

  generate
    for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[LAST];
  end

  assign pin_sync_o  = chain_q[LAST];
  assign pin_ahead_o = chain_q[LAST-1];
  assign pin_fall_o  = last_q && !chain_q[LAST];

  p_fall_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall_o |=> !pin_fall_o);

endmodule

// File: rtl/pdn_soft_state.sv
module pdn_soft_state
  import pdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_up_i,
  input  logic sw_down_i,
  input  logic pin_sync_i,
  input  logic pin_ahead_i,
  input  logic pin_fall_i,
  output logic soft_off_o,
  output logic core_active_o
);
  logic off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= soft_off_next(off_q, sw_up_i, sw_down_i, pin_fall_i);
  end

  assign soft_off_o    = off_q;
  assign core_active_o = core_on(pin_sync_i, off_q);

  p_pin_forces_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sync_i |-> !core_active_o);

  p_swdown_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_down_i |=> !core_active_o);

  p_swup_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_up_i && pin_ahead_i) |=> !core_active_o);

  p_swup_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_up_i && !sw_down_i && !pin_ahead_i) |=> core_active_o);

  p_fall_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_fall_i && !sw_down_i) |=> !soft_off_o);

  p_down_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_up_i && sw_down_i) |=> soft_off_o);

endmodule

// File: rtl/pdn_conv_guard.sv
module pdn_conv_guard
  import pdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_active_i,
  input  logic conv_busy_i,
  output logic abort_o,
  output logic done_o,
  output logic invalid_o
);
  logic active_q;
  logic busy_q;
  logic inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      busy_q   <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      active_q <= core_active_i;
      busy_q   <= conv_busy_i;
      inv_q    <= invalid_next(inv_q, abort_o, done_o);
    end
  end

  assign abort_o   = active_q && !core_active_i && busy_q;
  assign done_o    = busy_q && !conv_busy_i && core_active_i;
  assign invalid_o = inv_q;

  p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!core_active_i && busy_q));

  p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  p_abort_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> invalid_o);

  p_inv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_o && !done_o) |=> invalid_o);

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !abort_o) |=> !invalid_o);

endmodule

// File: rtl/pdn_arbiter.sv
module pdn_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin_i,
  input  logic sw_up_i,
  input  logic sw_down_i,
  input  logic conv_busy_i,
  output logic core_active_o,
  output logic conv_abort_o,
  output logic data_invalid_o
);
  localparam int STAGES_USED = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic pin_sync;
  logic pin_ahead;
  logic pin_fall;
  logic soft_off;
  logic active;
  logic abort_evt;
  logic done_evt;
  logic invalid;

  pdn_pin_sync #(.STAGES(STAGES_USED)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pd_pin_i),
    .pin_sync_o (pin_sync),
    .pin_ahead_o(pin_ahead),
    .pin_fall_o (pin_fall)
  );

  pdn_soft_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_up_i      (sw_up_i),
    .sw_down_i    (sw_down_i),
    .pin_sync_i   (pin_sync),
    .pin_ahead_i  (pin_ahead),
    .pin_fall_i   (pin_fall),
    .soft_off_o   (soft_off),
    .core_active_o(active)
  );

  pdn_conv_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_active_i(active),
    .conv_busy_i  (conv_busy_i),
    .abort_o      (abort_evt),
    .done_o       (done_evt),
    .invalid_o    (invalid)
  );

  assign core_active_o  = active;
  assign conv_abort_o   = abort_evt;
  assign data_invalid_o = invalid;

  p_off_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_active_o |-> (pin_sync || soft_off));

  p_abort_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_abort_o && !done_evt) |=> data_invalid_o);

endmodule

// File: tb/pdn_arbiter_tb.sv
`timescale 1ns/1ps
module pdn_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, up = 1'b0, down = 1'b0, busy = 1'b0;
  logic act, abrt, inv;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pdn_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .pd_pin_i(pin), .sw_up_i(up),
    .sw_down_i(down), .conv_busy_i(busy), .core_active_o(act),
    .conv_abort_o(abrt), .data_invalid_o(inv)
  );

  // Reference model kept from the requirements: pin pipeline of two edges,
  // a latch that remembers software shutdown, and the conversion bookkeeping.
  logic m_p1, m_p2, m_p3, m_off, m_was_on, m_busy_d, m_inv;

  function automatic logic exp_on(input logic p2, input logic off);
    return (p2 == 1'b0) && (off == 1'b0);
  endfunction

  function automatic logic exp_abort(input logic was_on, input logic now_on,
                                     input logic busy_d);
    return was_on && !now_on && busy_d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic on_now, ab_now, dn_now, fell;
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_off = 0;
      m_was_on = 1; m_busy_d = 0; m_inv = 0;
    end else begin
      on_now = exp_on(m_p2, m_off);
      ab_now = exp_abort(m_was_on, on_now, m_busy_d);
      dn_now = m_busy_d && !busy && on_now;
      fell   = m_p3 && !m_p2;
      if (ab_now) m_inv = 1; else if (dn_now) m_inv = 0;
      if (down) m_off = 1; else if (up || fell) m_off = 0;
      m_was_on = on_now;
      m_busy_d = busy;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin;
    end
  end

  task automatic chk(input string req, input logic got, input logic want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  task automatic model_cmp();
    logic on_e;
    on_e = exp_on(m_p2, m_off);
    chk("R2 model core_active", act, on_e);
    chk("R8 model abort", abrt, exp_abort(m_was_on, on_e, m_busy_d));
    chk("R9 model invalid", inv, m_inv);
  endtask

  // Drive inputs just after a falling edge, then compare at the next one.
  task automatic cyc(input logic p, input logic u, input logic d, input logic b);
    pin = p; up = u; down = d; busy = b;
    @(negedge clk);
    model_cmp();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_active", act, 1'b1);
    chk("R1 abort", abrt, 1'b0);
    chk("R1 invalid", inv, 1'b0);

    // R2 pin latency
    cyc(1, 0, 0, 0); chk("R2 one edge", act, 1'b1);
    cyc(1, 0, 0, 0); chk("R2 two edges", act, 1'b0);
    // R4 software up while pin high
    cyc(1, 1, 0, 0); chk("R4 up blocked", act, 1'b0);
    cyc(1, 0, 0, 0); chk("R4 still down", act, 1'b0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); chk("R4 pin low wakes", act, 1'b1);

    // R3 software down
    cyc(0, 0, 1, 0); chk("R3 down", act, 1'b0);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R3 stays down", act, 1'b0);
    // R5 software up wakes
    cyc(0, 1, 0, 0); chk("R5 up wakes", act, 1'b1);

    // R6 pin pulse wakes after software down
    cyc(0, 0, 1, 0);
    repeat (3) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); chk("R6 edge1", act, 1'b0);
    cyc(0, 0, 0, 0); chk("R6 edge2", act, 1'b0);
    cyc(0, 0, 0, 0); chk("R6 edge3", act, 1'b1);

    // R7 both strobes
    cyc(0, 1, 1, 0); chk("R7 down wins", act, 1'b0);
    cyc(0, 1, 0, 0); chk("R7 recover", act, 1'b1);
    // R7 down meets pin fall at synchronizer end
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0); chk("R7 down over fall", act, 1'b0);
    cyc(0, 0, 0, 0); chk("R7 latch kept", act, 1'b0);
    cyc(0, 1, 0, 0);

    // R8 no abort when idle
    cyc(0, 0, 1, 0); chk("R8 idle no abort", abrt, 1'b0);
    cyc(0, 1, 0, 1); cyc(0, 0, 0, 1);
    // R8 abort during conversion
    cyc(0, 0, 1, 1); chk("R8 abort pulse", abrt, 1'b1);
    chk("R9 not yet", inv, 1'b0);
    cyc(0, 0, 0, 1); chk("R8 single cycle", abrt, 1'b0);
    chk("R9 set", inv, 1'b1);
    cyc(0, 0, 0, 0); chk("R9 busy drop while off", inv, 1'b1);
    cyc(0, 1, 0, 0); chk("R9 kept after wake", inv, 1'b1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0); chk("R9 clears after done", inv, 1'b0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic np, nu, nd, nb;
      np = (($urandom % 16) == 0) ? ~pin : pin;
      nu = (($urandom % 10) == 0);
      nd = (($urandom % 12) == 0);
      nb = (($urandom % 6) == 0) ? ~busy : busy;
      cyc(np, nu, nd, nb);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule